// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the initiating side of a 16-bit bus on which address and data share the same wires. A core-side requester hands over one access at a time: an address, write data and a direction flag. The block runs the external sequence and then reports completion with a one-cycle response that carries the read data. On the external side it first drives the address together with an address strobe. It then asserts either the read strobe or the write strobe for the data phase. On a write it drives the data. On a read it releases the wires and captures what the slave returns.

All external timing is counted in bus cycles. A bus cycle is 2^div core cycles, where div is a 3-bit field, and the block publishes it on a bus-clock pin whose polarity and gating are selectable. The address phase is one bus cycle, or two when the address extension is on. The data phase is one bus cycle plus a programmed number of automatic wait cycles. When the ready function is on, the data phase is then stretched for as long as the slave holds ready low. The request port follows valid/ready rules. The requester may raise `req_valid` at any time and must hold it, with its fields stable, until `req_ready` is seen high at a clock edge. `req_ready` is high only on the last core cycle of a bus cycle while the block is idle and no response is being issued. The response is a plain one-cycle `rsp_valid` pulse with no back-pressure.

Top module: `mux_bus_master`

## Requirements
- R1: A request is accepted only at an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until after the `rsp_valid` pulse.
- R2: During the address phase, `bus_ad_out` carries the request address and `bus_ad_oe` is 1. The address strobe is active during this phase and inactive at every other time. `cfg_as_high`=1 makes the strobe active high; 0 makes it active low.
- R3: The address phase lasts one bus cycle when `cfg_addr_ext`=0 and two bus cycles when `cfg_addr_ext`=1.
- R4: During the data phase, exactly one of `bus_rd_n`/`bus_wr_n` is low. On a write, `bus_ad_out` carries the write data with `bus_ad_oe`=1. On a read, `bus_ad_oe`=0.
- R5: `cfg_wait` codes 0..7 add 0, 1, 2, 3, 4, 8, 16 or 32 bus cycles to the one-bus-cycle data phase.
- R6: After the wait cycles have elapsed, when `cfg_rdy_en`=1 the data phase ends at the first bus-cycle boundary where `bus_rdy` is sampled high. When `cfg_rdy_en`=0, `bus_rdy` has no effect.
- R7: On a read, `bus_ad_in` is captured at the edge that ends the data phase. `rsp_valid` is high for exactly one core cycle right after that edge, with the captured value on `rsp_rdata`. The number of core cycles from the accepting edge to that edge is 2^div × (address cycles + data cycles).
- R8: One bus cycle is 2^`cfg_div` core cycles. For div>0, the bus clock shows one active edge per bus cycle, at the start of the cycle. For div=0, the bus clock pin rests at its active level.
- R9: When `cfg_clk_inv`=0, the bus clock is high in the first half of each bus cycle and its idle level is 0. When `cfg_clk_inv`=1, the waveform is inverted, falling edges are active and the idle level is 1.
- R10: When `cfg_clk_suspend`=1, the bus clock pin holds its idle level while no access is running and toggles during an access. Internal timing is unaffected.
- R11: After reset, the address strobe is inactive, both data strobes are high, `bus_ad_oe`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request taken at this edge if valid |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| cfg_div | input | 3 | Bus-cycle length code (2^div core cycles) |
| cfg_clk_inv | input | 1 | Invert bus clock |
| cfg_clk_suspend | input | 1 | Gate bus clock when idle |
| cfg_as_high | input | 1 | Address strobe active high |
| cfg_wait | input | 3 | Automatic wait code |
| cfg_addr_ext | input | 1 | Extra address bus cycle |
| cfg_rdy_en | input | 1 | Honour external ready |
| bus_clk | output | 1 | Bus clock pin |
| bus_as | output | 1 | Address strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_out | output | 16 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for the AD wires |
| bus_ad_in | input | 16 | Multiplexed data in |
| bus_rdy | input | 1 | Slave ready |

## Verification
A wrong sequencer state shows at the pins within the same bus cycle. The affected signals are the strobes, the drive enable or the AD value, so a wrong state appears as strobes that overlap, a wrong address, or the bus driven during a read. A miscounted wait or ready decision first appears at the end of the access. It shows as a completion pulse that comes a whole number of bus cycles early or late, so the bench checks the exact core-cycle count from acceptance to the response. A bad divider shows within one 64-cycle idle window as a wrong count of bus-clock edges or a wrong resting level.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_ADDR2 = 2'd2,
    ST_DATA  = 2'd3
  } mbus_state_t;

  localparam int unsigned WAIT_CODE_W = 3;
  localparam int unsigned WAIT_CNT_W  = 6;

  function automatic logic [WAIT_CNT_W-1:0] wait_decode(input logic [WAIT_CODE_W-1:0] code);
    if (code < 3'd4) return WAIT_CNT_W'(code);
    return WAIT_CNT_W'(1) << (code - 3'd2);
  endfunction
endpackage

// File: rtl/mbus_clkgen.sv
module mbus_clkgen #(
  parameter int unsigned DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  input  logic            inv,
  input  logic            suspend,
  input  logic            busy,
  output logic            tick,
  output logic            bus_clk
);
  localparam int unsigned CW = (1 << DIVW) - 1;

  logic [CW-1:0] cnt;
  logic [CW:0]   one_hot;
  logic [CW:0]   mask;
  logic [CW:0]   top_bit;
  logic          raw;

  always_comb begin
    one_hot = {{CW{1'b0}}, 1'b1} << div;
    mask    = one_hot - 1'b1;
    top_bit = one_hot >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tick    = ((cnt & mask[CW-1:0]) == mask[CW-1:0]);
  assign raw     = ((cnt & top_bit[CW-1:0]) == '0);
  assign bus_clk = (suspend && !busy) ? inv : (raw ^ inv);

  // R8: for div>0, ticks are never back to back
  a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div != $past(div)));

  // R9: the bus clock is at its active level in the first core cycle of a bus cycle
  a_r9_active_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $stable(div) && !(suspend && !busy)) |-> (bus_clk != inv));
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   cfg_addr_ext,
  input  logic [WAIT_CODE_W-1:0] cfg_wait,
  input  logic                   cfg_rdy_en,
  input  logic                   rdy,
  output logic                   req_ready,
  output logic                   accept,
  output logic                   finish,
  output logic                   done,
  output logic                   busy,
  output logic                   is_write,
  output mbus_state_t            state
);
  logic [WAIT_CNT_W-1:0] wcnt;
  logic                  stall;

  assign req_ready = (state == ST_IDLE) && tick && !done;
  assign accept    = req_valid && req_ready;
  assign stall     = cfg_rdy_en && !rdy;
  assign finish    = (state == ST_DATA) && tick && (wcnt == '0) && !stall;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wcnt     <= '0;
      done     <= 1'b0;
      is_write <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_ADDR;
          is_write <= req_write;
        end
        ST_ADDR: if (tick) begin
          if (cfg_addr_ext) state <= ST_ADDR2;
          else begin
            state <= ST_DATA;
            wcnt  <= wait_decode(cfg_wait);
          end
        end
        ST_ADDR2: if (tick) begin
          state <= ST_DATA;
          wcnt  <= wait_decode(cfg_wait);
        end
        ST_DATA: if (tick) begin
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          else if (!stall) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a low ready seen after the waits keeps the data phase going
  a_r6_ready_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && tick && wcnt == '0 && cfg_rdy_en && !rdy) |=> (state == ST_DATA));

  // R5: wait cycles are consumed before any completion
  a_r5_wait_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && wcnt != '0) |=> (state == ST_DATA));

  // R1: nothing is accepted while an access is running
  a_r1_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !accept);
endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          finish,
  input  logic          is_write,
  input  mbus_state_t   state,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  input  logic          as_high,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          as_o,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          in_addr;
  logic          in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (finish && !is_write) rdata <= ad_in;
    end
  end

  assign in_addr = (state == ST_ADDR) || (state == ST_ADDR2);
  assign in_data = (state == ST_DATA);
  assign as_o    = as_high ? in_addr : !in_addr;
  assign rd_n    = !(in_data && !is_write);
  assign wr_n    = !(in_data && is_write);
  assign ad_oe   = in_addr || (in_data && is_write);
  assign ad_out  = in_data ? wdata_q : addr_q;

  // R4: never both data strobes
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n) rd_n || wr_n);

  // R4: the wires are released while reading
  a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe);

  // R2: the address stays put while the strobe is active
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_addr && $past(in_addr)) |-> $stable(ad_out));
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbus_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned DIVW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [DW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic                   req_write,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  input  logic [DIVW-1:0]        cfg_div,
  input  logic                   cfg_clk_inv,
  input  logic                   cfg_clk_suspend,
  input  logic                   cfg_as_high,
  input  logic [WAIT_CODE_W-1:0] cfg_wait,
  input  logic                   cfg_addr_ext,
  input  logic                   cfg_rdy_en,
  output logic                   bus_clk,
  output logic                   bus_as,
  output logic                   bus_rd_n,
  output logic                   bus_wr_n,
  output logic [DW-1:0]          bus_ad_out,
  output logic                   bus_ad_oe,
  input  logic [DW-1:0]          bus_ad_in,
  input  logic                   bus_rdy
);
  logic        tick;
  logic        accept;
  logic        finish;
  logic        busy;
  logic        is_write;
  mbus_state_t state;

  mbus_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .inv(cfg_clk_inv),
    .suspend(cfg_clk_suspend), .busy(busy), .tick(tick), .bus_clk(bus_clk)
  );

  mbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_write(req_write), .cfg_addr_ext(cfg_addr_ext), .cfg_wait(cfg_wait),
    .cfg_rdy_en(cfg_rdy_en), .rdy(bus_rdy), .req_ready(req_ready),
    .accept(accept), .finish(finish), .done(rsp_valid), .busy(busy),
    .is_write(is_write), .state(state)
  );

  mbus_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish),
    .is_write(is_write), .state(state), .req_addr(req_addr),
    .req_wdata(req_wdata), .ad_in(bus_ad_in), .as_high(cfg_as_high),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .as_o(bus_as),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .rdata(rsp_rdata)
  );

  // R7: the completion pulse lasts one core cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R1: the bus is quiet whenever a request can be taken
  a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rd_n && bus_wr_n && !bus_ad_oe && bus_as != cfg_as_high));

  // R2: the address strobe never overlaps a data strobe
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as == cfg_as_high) |-> (bus_rd_n && bus_wr_n));
endmodule

// File: tb/sim_mux_bus_master.sv
module sim_mux_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [2:0]  cfg_div = 3'd1;
  logic        cfg_clk_inv = 1'b0;
  logic        cfg_clk_suspend = 1'b0;
  logic        cfg_as_high = 1'b1;
  logic [2:0]  cfg_wait = 3'd0;
  logic        cfg_addr_ext = 1'b0;
  logic        cfg_rdy_en = 1'b0;
  logic        bus_clk, bus_as, bus_rd_n, bus_wr_n, bus_ad_oe;
  logic [15:0] bus_ad_out;
  logic [15:0] bus_ad_in = 16'hDEAD;
  logic        bus_rdy = 1'b1;

  int errors = 0;
  int checks = 0;

  always #10 clk = !clk;

  mux_bus_master u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_div(cfg_div),
    .cfg_clk_inv(cfg_clk_inv), .cfg_clk_suspend(cfg_clk_suspend),
    .cfg_as_high(cfg_as_high), .cfg_wait(cfg_wait), .cfg_addr_ext(cfg_addr_ext),
    .cfg_rdy_en(cfg_rdy_en), .bus_clk(bus_clk), .bus_as(bus_as),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_rdy(bus_rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wait_cycles(input int code);
    if (code < 4) return code;
    return 1 << (code - 2);
  endfunction

  function automatic int expect_k(input int div, input int wt, input int ext,
                                  input int ren, input int hold);
    int n = 1 << div;
    int k0 = 2 + ext + wait_cycles(wt);
    int kr = hold / n + 1;
    if (ren != 0 && kr > k0) return kr;
    return k0;
  endfunction

  task automatic run_txn(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input int div, input int wt, input int ext, input int ren,
                         input int hold, input bit inv, input bit ash, input bit susp);
    int n = 1 << div;
    int k = expect_k(div, wt, ext, ren, hold);
    int e = 0;
    int t = -1;
    int as_cnt = 0, st_cnt = 0, toggles = 0, busy_ready = 0, rd_drive = 0;
    logic [15:0] a_seen = '0, w_seen = '0;
    logic prev_clk;
    int guard = 0;
    @(negedge clk);
    cfg_div = 3'(div); cfg_wait = 3'(wt); cfg_addr_ext = 1'(ext); cfg_rdy_en = 1'(ren);
    cfg_clk_inv = inv; cfg_as_high = ash; cfg_clk_suspend = susp;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    bus_rdy = (hold >= 1) ? 1'b0 : 1'b1;
    bus_ad_in = 16'hDEAD;
    #1;
    while (!req_ready && guard < 2000) begin
      @(negedge clk); #1; guard++;
    end
    @(posedge clk);
    prev_clk = bus_clk;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (rsp_valid) begin t = e; break; end
      if (req_ready) busy_ready++;
      if (bus_as == ash) begin
        as_cnt++;
        a_seen = bus_ad_out;
        if (!bus_ad_oe) busy_ready++;
      end
      if (!bus_rd_n || !bus_wr_n) st_cnt++;
      if (!bus_wr_n) w_seen = bus_ad_out;
      if (!bus_rd_n && bus_ad_oe) rd_drive++;
      if (bus_clk != prev_clk) toggles++;
      prev_clk = bus_clk;
      bus_ad_in = !bus_rd_n ? d : 16'hDEAD;
      bus_rdy = (e + 1 <= hold) ? 1'b0 : 1'b1;
      @(posedge clk);
      e++;
    end
    // R5/R6/R7: total access length in core cycles
    chk(t == n * k, "R5/R6/R7 access length", t, n * k);
    // R3: address phase length, R2 strobe polarity
    chk(as_cnt == n * (1 + ext), "R3 address phase cycles", as_cnt, n * (1 + ext));
    chk(a_seen == a, "R2 address on AD", int'(a_seen), int'(a));
    chk(st_cnt == n * (k - 1 - ext), "R4 data strobe cycles", st_cnt, n * (k - 1 - ext));
    chk(busy_ready == 0, "R1 ready or drive while busy", busy_ready, 0);
    if (wr) chk(w_seen == d, "R4 write data on AD", int'(w_seen), int'(d));
    else begin
      chk(rsp_rdata == d, "R7 read data", int'(rsp_rdata), int'(d));
      chk(rd_drive == 0, "R4 AD released on read", rd_drive, 0);
    end
    if (susp && div > 0) chk(toggles > 0, "R10 clock runs during access", toggles, 1);
    @(negedge clk);
    chk(!rsp_valid, "R7 single pulse", int'(rsp_valid), 0);
    bus_rdy = 1'b1;
  endtask

  task automatic clk_check(input int div, input bit inv, input bit susp);
    int act_edges = 0, wrong_lvl = 0, exp_edges;
    logic prev;
    @(negedge clk);
    cfg_div = 3'(div); cfg_clk_inv = inv; cfg_clk_suspend = susp;
    repeat (2) @(negedge clk);
    prev = bus_clk;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (prev == inv && bus_clk != inv) act_edges++;
      if ((susp || div == 0) && bus_clk != (susp ? inv : !inv)) wrong_lvl++;
      prev = bus_clk;
    end
    exp_edges = (susp || div == 0) ? 0 : (64 >> div);
    chk(act_edges == exp_edges, "R8/R9/R10 bus clock active edges", act_edges, exp_edges);
    chk(wrong_lvl == 0, "R9/R10 bus clock resting level", wrong_lvl, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(bus_as == 1'b0, "R11 strobe inactive", int'(bus_as), 0);
    chk(bus_rd_n && bus_wr_n, "R11 data strobes high", int'({bus_rd_n, bus_wr_n}), 3);
    chk(!bus_ad_oe, "R11 AD not driven", int'(bus_ad_oe), 0);
    chk(!rsp_valid, "R11 no response", int'(rsp_valid), 0);
    rst_n = 1'b1;

    // directed corners
    run_txn(1'b0, 16'h07FC, 16'h1234, 1, 0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    run_txn(1'b1, 16'h0402, 16'hBEEF, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    run_txn(1'b0, 16'h0010, 16'hA5A5, 2, 7, 1, 0, 0, 1'b1, 1'b1, 1'b1);
    run_txn(1'b1, 16'h0123, 16'h0F0F, 1, 4, 0, 1, 40, 1'b0, 1'b1, 1'b0);
    // R6: ready disabled, held low, no effect
    run_txn(1'b0, 16'h0222, 16'h5A5A, 1, 2, 0, 0, 500, 1'b0, 1'b1, 1'b0);
    // R6: ready released exactly on a boundary
    run_txn(1'b0, 16'h0333, 16'hC3C3, 2, 0, 0, 1, 15, 1'b0, 1'b0, 1'b0);
    run_txn(1'b1, 16'h0444, 16'h3C3C, 7, 0, 1, 0, 0, 1'b1, 1'b1, 1'b1);

    clk_check(2, 1'b0, 1'b0);
    clk_check(3, 1'b1, 1'b0);
    clk_check(1, 1'b0, 1'b1);
    clk_check(2, 1'b1, 1'b1);
    clk_check(0, 1'b0, 1'b0);

    for (int j = 0; j < 25; j++) begin
      run_txn(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
              int'($urandom_range(0, 60)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule